// File: doc/BRIEF.md
# Load Address Generation Unit

This unit computes the memory address for a family of 32-bit load instructions and, for the two auto-modifying pointer modes, the pointer value to write back. Each request carries an addressing mode, an access size, the base pointer, an index operand, the current program-counter and stack-pointer values, a raw displacement field, a shift amount and a byte-lane selector. The mode decides how the displacement is extended (zero or sign), how many of its bits count, and whether it is scaled by the access size.

The unit is a single registered stage with a valid/ready handshake on both sides. A request is taken at a rising edge when `in_valid` and `in_ready` are both high. Its result appears on the outputs one cycle later with `out_valid` high. The result stays there, unchanged, until a rising edge that sees `out_ready` high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so a full stage under back-pressure refuses new work. Memory access, data formatting, condition evaluation and register storage happen elsewhere.

Top module: `ld_agu`

## Requirements
- R1: Mode 0 (post-increment) gives address = base and write-back = base + step, where step is 1, 2, 4 or 8 for size code 0, 1, 2 or 3. Write-back enable is 1.
- R2: Mode 1 (pre-decrement) gives address = write-back = base − step, with write-back enable 1.
- R3: Mode 2 (short displacement) adds to the base a zero-extended field, shifted left by the size code. The field is disp[4:0] when the size code is 2 (word) and disp[2:0] for every other size.
- R4: Mode 3 (long displacement) adds the sign-extended disp[15:0] to the base, without scaling.
- R5: Mode 4 (indexed) adds index shifted left by the 2-bit shift amount (0 to 3) to the base.
- R6: Mode 5 (lane index) takes byte lane `in_part` of the index (lane 0 = bits 7:0, lane 3 = bits 31:24). It zero-extends the lane, shifts it left by 2 and adds it to the base.
- R7: Mode 6 (conditional form) adds the zero-extended disp[8:0], shifted left by the size code, to the base.
- R8: Mode 7 uses the program counter and mode 8 uses the stack pointer. In both, the two low bits of that value are cleared, and the zero-extended disp[6:0] shifted left by 2 is added. The resulting address is always word aligned.
- R9: Mode 9 (mid displacement) adds the sign-extended disp[11:0], shifted left by the size code, to the base.
- R10: Write-back enable is 0 for every mode other than 0 and 1, and the write-back value is then the unchanged base. Mode codes 10 to 15 are reserved and give address = base.
- R11: All address and pointer arithmetic wraps modulo 2^32.
- R12: A result appears one cycle after its request is accepted. `in_ready` = !out_valid || out_ready. While out_valid is high and out_ready is low, all outputs hold. Results leave in the order they were accepted, with none lost or duplicated.
- R13: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can take a request this cycle |
| in_mode | input | 4 | Addressing mode code (0–9, rest reserved) |
| in_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| in_base | input | 32 | Base pointer value |
| in_index | input | 32 | Index operand |
| in_pc | input | 32 | Program-counter value |
| in_sp | input | 32 | Stack-pointer value |
| in_disp | input | 16 | Raw displacement field |
| in_shamt | input | 2 | Index shift amount |
| in_part | input | 2 | Byte lane of the index for mode 5 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 32 | Effective address |
| out_wb_data | output | 32 | Pointer write-back value |
| out_wb_en | output | 1 | Pointer write-back enable |

## Verification
Every result is due exactly one clock after the edge that accepted its request. It then stays on the outputs until the edge that sees `out_ready` high. The bench drives its inputs just after the falling edge and decides whether each side transfers a moment later, while the values at the next rising edge are already settled. It computes the expected result of every accepted request at that moment and queues it in order. It compares a queued entry only when the outputs transfer, checks that `out_valid` is high on the cycle after every acceptance, and checks that nothing moves on any cycle that was stalled in the previous one.

// File: rtl/lagu_pkg.sv
package lagu_pkg;
  localparam int ADDR_W = 32;
  localparam int DISP_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = ADDR_W / LANE_W;
  localparam int PART_W = $clog2(LANES);
  localparam int SHA_W  = 2;

  typedef enum logic [3:0] {
    AM_POSTINC = 4'd0,
    AM_PREDEC  = 4'd1,
    AM_DSHORT  = 4'd2,
    AM_DLONG   = 4'd3,
    AM_INDEX   = 4'd4,
    AM_XINDEX  = 4'd5,
    AM_COND    = 4'd6,
    AM_PCREL   = 4'd7,
    AM_SPREL   = 4'd8,
    AM_DMID    = 4'd9
  } am_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} sz_e;

  typedef enum logic [1:0] {BS_PTR = 2'd0, BS_PC = 2'd1, BS_SP = 2'd2} bsel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] wb_data;
    logic              wb_en;
  } agu_res_t;
endpackage

// File: rtl/lagu_offset.sv
module lagu_offset
  import lagu_pkg::*;
(
  input  am_e               mode,
  input  sz_e               size,
  input  logic [ADDR_W-1:0] index,
  input  logic [DISP_W-1:0] disp,
  input  logic [SHA_W-1:0]  shamt,
  input  logic [PART_W-1:0] part,
  output logic [ADDR_W-1:0] offset,
  output bsel_e             bsel
);
  localparam int SHORT_NW = 3;
  localparam int SHORT_WW = 5;
  localparam int COND_W   = 9;
  localparam int REL_W    = 7;
  localparam int MID_W    = 12;
  localparam int WSHIFT   = 2;

  logic [LANE_W-1:0] lane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = index[g*LANE_W +: LANE_W];
  end

  logic [ADDR_W-1:0] short_f, cond_f, rel_f, mid_f, long_f, lane_f;

  always_comb begin
    short_f = (size == SZ_W) ? ADDR_W'(disp[SHORT_WW-1:0]) : ADDR_W'(disp[SHORT_NW-1:0]);
    cond_f  = ADDR_W'(disp[COND_W-1:0]);
    rel_f   = ADDR_W'(disp[REL_W-1:0]);
    mid_f   = {{(ADDR_W-MID_W){disp[MID_W-1]}}, disp[MID_W-1:0]};
    long_f  = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    lane_f  = ADDR_W'(lane[part]);
    bsel    = BS_PTR;
    case (mode)
      AM_DSHORT: offset = short_f << size;
      AM_DLONG:  offset = long_f;
      AM_INDEX:  offset = index << shamt;
      AM_XINDEX: offset = lane_f << WSHIFT;
      AM_COND:   offset = cond_f << size;
      AM_PCREL: begin
        offset = rel_f << WSHIFT;
        bsel   = BS_PC;
      end
      AM_SPREL: begin
        offset = rel_f << WSHIFT;
        bsel   = BS_SP;
      end
      AM_DMID:   offset = mid_f << size;
      default:   offset = '0;
    endcase
  end
endmodule

// File: rtl/lagu_step.sv
module lagu_step
  import lagu_pkg::*;
(
  input  sz_e               size,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_inc,
  output logic [ADDR_W-1:0] ptr_dec
);
  logic [ADDR_W-1:0] step;
  assign step    = ADDR_W'(1) << size;
  assign ptr_inc = ptr + step;
  assign ptr_dec = ptr - step;
endmodule

// File: rtl/lagu_stage.sv
module lagu_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  // R12: a stalled result neither vanishes nor changes
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R12: the output only fills from an offered request
  p_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
endmodule

// File: rtl/ld_agu.sv
module ld_agu
  import lagu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [3:0]          in_mode,
  input  logic [1:0]          in_size,
  input  logic [ADDR_W-1:0]   in_base,
  input  logic [ADDR_W-1:0]   in_index,
  input  logic [ADDR_W-1:0]   in_pc,
  input  logic [ADDR_W-1:0]   in_sp,
  input  logic [DISP_W-1:0]   in_disp,
  input  logic [SHA_W-1:0]    in_shamt,
  input  logic [PART_W-1:0]   in_part,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [ADDR_W-1:0]   out_wb_data,
  output logic                out_wb_en
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
  localparam int RES_W = $bits(agu_res_t);

  am_e mode;
  sz_e size;
  assign mode = am_e'(in_mode);
  assign size = sz_e'(in_size);

  logic [ADDR_W-1:0] offset, ptr_inc, ptr_dec, base_eff;
  bsel_e             bsel;
  agu_res_t          c_res, q_res;

  lagu_offset u_offset (
    .mode(mode), .size(size), .index(in_index), .disp(in_disp),
    .shamt(in_shamt), .part(in_part), .offset(offset), .bsel(bsel)
  );

  lagu_step u_step (
    .size(size), .ptr(in_base), .ptr_inc(ptr_inc), .ptr_dec(ptr_dec)
  );

  always_comb begin
    case (bsel)
      BS_PC:   base_eff = in_pc & WORD_MASK;
      BS_SP:   base_eff = in_sp & WORD_MASK;
      default: base_eff = in_base;
    endcase
    c_res.addr    = base_eff + offset;
    c_res.wb_data = in_base;
    c_res.wb_en   = 1'b0;
    if (mode == AM_POSTINC) begin
      c_res.addr    = in_base;
      c_res.wb_data = ptr_inc;
      c_res.wb_en   = 1'b1;
    end else if (mode == AM_PREDEC) begin
      c_res.addr    = ptr_dec;
      c_res.wb_data = ptr_dec;
      c_res.wb_en   = 1'b1;
    end
  end

  lagu_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(c_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(q_res)
  );

  assign out_addr    = q_res.addr;
  assign out_wb_data = q_res.wb_data;
  assign out_wb_en   = q_res.wb_en;

  // R1: write-back lies exactly one step above the address
  p_postinc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_POSTINC |-> (c_res.wb_data - c_res.addr) == (ADDR_W'(1) << in_size));

  // R2: address and written pointer agree, and the pointer moved
  p_predec_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_PREDEC |-> c_res.addr == c_res.wb_data && c_res.wb_data != in_base);

  // R8: PC- and SP-relative addresses are word aligned
  p_rel_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (mode == AM_PCREL || mode == AM_SPREL) |-> c_res.addr[1:0] == 2'b00);

  // R10: non-pointer modes leave the pointer alone
  p_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode != AM_POSTINC && mode != AM_PREDEC |-> !c_res.wb_en && c_res.wb_data == in_base);
endmodule

// File: tb/test_ld_agu.sv
module test_ld_agu;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH = 8192;
  localparam int NRAND = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mode = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_base = '0, in_index = '0, in_pc = '0, in_sp = '0;
  logic [15:0] in_disp = '0;
  logic [1:0]  in_shamt = '0, in_part = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr, out_wb_data;
  logic        out_wb_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_agu i_ld_agu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_size(in_size), .in_base(in_base), .in_index(in_index),
    .in_pc(in_pc), .in_sp(in_sp), .in_disp(in_disp), .in_shamt(in_shamt),
    .in_part(in_part), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_wb_data(out_wb_data), .out_wb_en(out_wb_en)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [64:0] exp_q [QDEPTH];
  string       tag_q [QDEPTH];
  int wr = 0;
  int rd = 0;
  bit acc_prev = 1'b0;
  bit hold_prev = 1'b0;
  logic [64:0] held;
  string cur_tag = "";

  task automatic check(input string req, input bit ok, input logic [64:0] act, input logic [64:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string mode_tag(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7, 4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  // expected {addr, wb_data, wb_en} from the requirements
  function automatic logic [64:0] ref_model(
    input logic [3:0] m, input logic [1:0] s, input logic [31:0] b, x, pc, sp,
    input logic [15:0] d, input logic [1:0] sa, pt);
    logic [31:0] a, w, sc;
    logic e;
    sc = 32'd1 << s;
    a = b; w = b; e = 1'b0;
    case (m)
      4'd0: begin a = b; w = b + sc; e = 1'b1; end
      4'd1: begin a = b - sc; w = a; e = 1'b1; end
      4'd2: a = b + ((s == 2'd2) ? {27'd0, d[4:0]} : {29'd0, d[2:0]}) * sc;
      4'd3: a = b + {{16{d[15]}}, d};
      4'd4: a = b + x * (32'd1 << sa);
      4'd5: a = b + ((x >> (8 * pt)) & 32'hFF) * 32'd4;
      4'd6: a = b + {23'd0, d[8:0]} * sc;
      4'd7: a = {pc[31:2], 2'b00} + {25'd0, d[6:0]} * 32'd4;
      4'd8: a = {sp[31:2], 2'b00} + {25'd0, d[6:0]} * 32'd4;
      4'd9: a = b + {{20{d[11]}}, d[11:0]} * sc;
      default: ;
    endcase
    return {a, w, e};
  endfunction

  // called just after driving at a falling edge; ends at the next falling edge
  task automatic step_cycle();
    logic [64:0] outv;
    #1;
    outv = {out_addr, out_wb_data, out_wb_en};
    if (acc_prev) check("R12 latency", out_valid === 1'b1, {64'd0, out_valid}, 65'd1);
    if (hold_prev) check("R12 hold", out_valid === 1'b1 && outv === held, outv, held);
    if (out_valid && out_ready) begin
      if (rd >= wr) check("R12 extra output", 1'b0, outv, '0);
      else begin
        check(tag_q[rd % QDEPTH], outv === exp_q[rd % QDEPTH], outv, exp_q[rd % QDEPTH]);
        rd++;
      end
    end
    hold_prev = out_valid && !out_ready;
    held = outv;
    acc_prev = in_valid && in_ready;
    if (acc_prev) begin
      exp_q[wr % QDEPTH] = ref_model(in_mode, in_size, in_base, in_index, in_pc, in_sp,
                                     in_disp, in_shamt, in_part);
      tag_q[wr % QDEPTH] = (cur_tag != "") ? cur_tag : mode_tag(in_mode);
      wr++;
    end
    @(negedge clk);
  endtask

  task automatic put(input string t, input logic [3:0] m, input logic [1:0] s,
                     input logic [31:0] b, x, pc, sp, input logic [15:0] d,
                     input logic [1:0] sa, pt);
    cur_tag = t;
    in_valid = 1'b1; out_ready = 1'b1;
    in_mode = m; in_size = s; in_base = b; in_index = x; in_pc = pc; in_sp = sp;
    in_disp = d; in_shamt = sa; in_part = pt;
    step_cycle();
    cur_tag = "";
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 out_valid", out_valid === 1'b0, {64'd0, out_valid}, 65'd0);
    rst_n = 1'b1;
    #1;
    check("R13 in_ready", in_ready === 1'b1, {64'd0, in_ready}, 65'd1);
    check("R13 out_valid after", out_valid === 1'b0, {64'd0, out_valid}, 65'd0);
    @(negedge clk);

    // directed corner cases
    put("R1 R11 wrap inc", 4'd0, 2'd3, 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 0);
    put("R2 R11 wrap dec", 4'd1, 2'd1, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
    put("R2 byte",         4'd1, 2'd0, 32'h0000_1000, 0, 0, 0, 0, 0, 0);
    put("R3 word field",   4'd2, 2'd2, 32'h0000_0100, 0, 0, 0, 16'hFFFF, 0, 0);
    put("R3 half field",   4'd2, 2'd1, 32'h0000_0100, 0, 0, 0, 16'hFFFF, 0, 0);
    put("R4 negative",     4'd3, 2'd2, 32'h0000_0010, 0, 0, 0, 16'h8000, 0, 0);
    put("R5 shift 3",      4'd4, 2'd2, 32'h0000_0000, 32'h10, 0, 0, 0, 2'd3, 0);
    put("R6 top lane",     4'd5, 2'd2, 32'h0000_0004, 32'hAB00_0000, 0, 0, 0, 0, 2'd3);
    put("R6 low lane",     4'd5, 2'd2, 32'h0000_0004, 32'h00FF_00CD, 0, 0, 0, 0, 2'd0);
    put("R7 dword max",    4'd6, 2'd3, 32'h0000_0000, 0, 0, 0, 16'hFFFF, 0, 0);
    put("R8 pc align",     4'd7, 2'd2, 0, 0, 32'h0000_1003, 0, 16'h007F, 0, 0);
    put("R8 sp align",     4'd8, 2'd2, 0, 0, 0, 32'h0000_2002, 16'hFF81, 0, 0);
    put("R9 half neg",     4'd9, 2'd1, 32'h0000_2000, 0, 0, 0, 16'h0800, 0, 0);
    put("R10 reserved",    4'd12, 2'd2, 32'h1234_5678, 32'h1, 0, 0, 16'h7FFF, 0, 0);
    put("R10 no wb",       4'd3, 2'd2, 32'h1234_5678, 0, 0, 0, 16'h0004, 0, 0);
    put("R11 wrap add",    4'd3, 2'd2, 32'hFFFF_FFF0, 0, 0, 0, 16'h0020, 0, 0);

    // constrained random with back-pressure
    for (int i = 0; i < NRAND; i++) begin
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      in_mode   = 4'($urandom % 12);
      in_size   = 2'($urandom);
      in_base   = $urandom;
      in_index  = $urandom;
      in_pc     = $urandom;
      in_sp     = $urandom;
      in_disp   = 16'($urandom);
      in_shamt  = 2'($urandom);
      in_part   = 2'($urandom);
      step_cycle();
    end

    // drain
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) step_cycle();
    check("R12 all delivered", rd == wr, 65'(rd), 65'(wr));
    check("R12 empty", out_valid === 1'b0, {64'd0, out_valid}, 65'd0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule